// File: doc/BRIEF.md
# Feature Card Initialisation Handshake Sequencer

This block watches the host's accesses to the four command registers of one plug-in feature card and tracks how far the host has got through the initialisation handshake. Accesses to the identification register or the vector register form the first command, called INT0. An access to the control register forms the second command, called INT1. An access to the status register restarts the handshake. Two state bits record whether INT0 and whether INT1 have been seen since the last restart.

Initialisation must fire on whichever of INT0 or INT1 arrives second after a restart, so both orders are accepted. Once both commands have been seen, a further INT0 starts an express job and a further INT1 starts a full job. The block issues one-cycle start pulses for initialisation, express and full jobs, and drives read data: card identification bytes before the handshake has seen INT1, and the interrupt vector once it has. The jobs themselves are carried out elsewhere.

The asynchronous active-low reset is released through a small synchroniser, so the block is held idle for two clocks after `rst_n` rises.

Top module: `card_init_sequencer`

## Requirements
- R1: After reset both handshake bits are clear; with `acc_valid` low all start pulses and `rd_data` are zero.
- R2: An access with `reg_sel` = 3 (status) clears both handshake bits, read or write, so the next INT0 read again returns identification bytes.
- R3: An INT0 access (`reg_sel` = 0 identification, `reg_sel` = 1 vector) while INT1 has not been seen pulses nothing; a read returns `card_id[15:8]` for `reg_sel` = 0 and `card_id[7:0]` for `reg_sel` = 1.
- R4: An INT0 access when only INT1 has been seen pulses `start_init`; a read returns `irq_vec`.
- R5: An INT1 access (`reg_sel` = 2) when only INT0 has been seen pulses `start_init`.
- R6: An INT0 access when both bits are set pulses `start_express`; a read returns `irq_vec`.
- R7: An INT1 access when both bits are set pulses `start_full`.
- R8: An INT1 access when INT0 has not been seen pulses nothing.
- R9: Reads of the control and status registers, and every write, return zero on `rd_data`.
- R10: Writes make the same state changes and start pulses as reads of the same register.
- R11: Each start pulse is high only in the cycle of the triggering access, at most one is high at a time, and the handshake bits hold when no access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access accepted this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| reg_sel | input | 2 | 0 identification, 1 vector, 2 control, 3 status |
| card_id | input | 16 | Card identification code |
| irq_vec | input | 8 | Stored interrupt vector |
| rd_data | output | 8 | Read data for the current access |
| start_init | output | 1 | One-cycle initialisation start |
| start_express | output | 1 | One-cycle express job start |
| start_full | output | 1 | One-cycle full job start |

## Verification
Start pulses and read data are combinational from the access and the current handshake bits, so they are due in the same cycle as the access; the bench drives each access on the falling edge and compares shortly after, before the rising edge. The handshake bits change on the rising edge that ends the access, so their effect is seen only on the next access, which the reference model mirrors by updating its own bits after the comparison. Directed sequences cover both handshake orders, restart, writes and idle cycles, followed by a long pseudo-random access stream.

// File: rtl/card_init_pkg.sv
package card_init_pkg;

  typedef enum logic [1:0] {
    SEL_IDENT  = 2'd0,
    SEL_VECTOR = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STATUS = 2'd3
  } card_sel_e;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_FIRST = 2'd1,
    CMD_SECOND = 2'd2,
    CMD_CLEAR = 2'd3
  } card_cmd_e;

  typedef struct packed {
    logic got_first;
    logic got_second;
  } hs_state_t;

endpackage

// File: rtl/card_rst_sync.sv
module card_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/card_cmd_decode.sv
module card_cmd_decode
  import card_init_pkg::*;
(
  input  logic      acc_valid,
  input  card_sel_e sel,
  output card_cmd_e cmd
);
  always_comb begin
    cmd = CMD_NONE;
    if (acc_valid) begin
      unique case (sel)
        SEL_IDENT, SEL_VECTOR: cmd = CMD_FIRST;
        SEL_CTRL:              cmd = CMD_SECOND;
        SEL_STATUS:            cmd = CMD_CLEAR;
        default:               cmd = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/card_hs_track.sv
module card_hs_track
  import card_init_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  card_cmd_e cmd,
  output hs_state_t state
);
  hs_state_t state_q, state_d;
  logic      state_en;

  assign state_en = (cmd != CMD_NONE);

  always_comb begin
    state_d = state_q;
    unique case (cmd)
      CMD_FIRST:  state_d.got_first  = 1'b1;
      CMD_SECOND: state_d.got_second = 1'b1;
      CMD_CLEAR:  state_d            = '0;
      default:    state_d            = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= '0;
    else if (state_en) state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/card_hs_action.sv
module card_hs_action
  import card_init_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ID_W   = 16
) (
  input  card_cmd_e         cmd,
  input  card_sel_e         sel,
  input  logic              acc_write,
  input  hs_state_t         state,
  input  logic [ID_W-1:0]   card_id,
  input  logic [DATA_W-1:0] irq_vec,
  output logic [DATA_W-1:0] rd_data,
  output logic              go_init,
  output logic              go_express,
  output logic              go_full
);
  localparam int ID_HI_LSB = ID_W - DATA_W;

  logic both_seen;
  logic [DATA_W-1:0] ident_byte;

  assign both_seen = state.got_first & state.got_second;

  always_comb begin
    go_init    = 1'b0;
    go_express = 1'b0;
    go_full    = 1'b0;
    unique case (cmd)
      CMD_FIRST: begin
        go_init    = state.got_second & ~state.got_first;
        go_express = both_seen;
      end
      CMD_SECOND: begin
        go_init = state.got_first & ~state.got_second;
        go_full = both_seen;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (sel == SEL_IDENT) ident_byte = card_id[ID_HI_LSB +: DATA_W];
    else                  ident_byte = card_id[DATA_W-1:0];
  end

  always_comb begin
    rd_data = '0;
    if (cmd == CMD_FIRST && !acc_write) begin
      if (state.got_second) rd_data = irq_vec;
      else                  rd_data = ident_byte;
    end
  end
endmodule

// File: rtl/card_init_sequencer.sv
module card_init_sequencer
  import card_init_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ID_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        reg_sel,
  input  logic [ID_W-1:0]   card_id,
  input  logic [DATA_W-1:0] irq_vec,
  output logic [DATA_W-1:0] rd_data,
  output logic              start_init,
  output logic              start_express,
  output logic              start_full
);
  logic      rst_n_sync;
  card_sel_e sel;
  card_cmd_e cmd;
  hs_state_t hs;
  logic      seen0, seen1;

  assign sel   = card_sel_e'(reg_sel);
  assign seen0 = hs.got_first;
  assign seen1 = hs.got_second;

  card_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  card_cmd_decode u_dec (
    .acc_valid(acc_valid & rst_n_sync), .sel(sel), .cmd(cmd)
  );

  card_hs_track u_trk (
    .clk(clk), .rst_n(rst_n_sync), .cmd(cmd), .state(hs)
  );

  card_hs_action #(.DATA_W(DATA_W), .ID_W(ID_W)) u_act (
    .cmd(cmd), .sel(sel), .acc_write(acc_write), .state(hs),
    .card_id(card_id), .irq_vec(irq_vec), .rd_data(rd_data),
    .go_init(start_init), .go_express(start_express), .go_full(start_full)
  );
endmodule

// File: rtl/card_init_sequencer_chk.sv
module card_init_sequencer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n_sync,
  input logic              acc_valid,
  input logic [1:0]        reg_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              start_init,
  input logic              start_express,
  input logic              start_full,
  input logic              seen0,
  input logic              seen1
);
  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $onehot0({start_init, start_express, start_full})); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !acc_valid |-> !(start_init | start_express | start_full) && rd_data == '0); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !acc_valid |=> $stable({seen0, seen1})); // R11
  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    acc_valid && reg_sel == 2'd3 |=> !seen0 && !seen1); // R2
  AST_INIT_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n_sync)
    start_init |=> seen0 && seen1); // R4
  AST_EXPRESS_AFTER_BOTH: assert property (@(posedge clk) disable iff (!rst_n_sync)
    start_express |-> seen0 && seen1 && reg_sel != 2'd2); // R6
  AST_FULL_ON_CTRL: assert property (@(posedge clk) disable iff (!rst_n_sync)
    start_full |-> seen0 && seen1 && reg_sel == 2'd2); // R7
endmodule

bind card_init_sequencer card_init_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n_sync(rst_n_sync), .acc_valid(acc_valid), .reg_sel(reg_sel),
  .rd_data(rd_data), .start_init(start_init), .start_express(start_express),
  .start_full(start_full), .seen0(seen0), .seen1(seen1)
);

// File: tb/card_init_sequencer_test.sv
module card_init_sequencer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic [1:0]  reg_sel;
  logic [15:0] card_id;
  logic [7:0]  irq_vec;
  logic [7:0]  rd_data;
  logic        start_init, start_express, start_full;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int m0 = 0, m1 = 0, after_clear = 0;
  int lfsr = 32'h1ace;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_init_sequencer uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .reg_sel(reg_sel), .card_id(card_id), .irq_vec(irq_vec), .rd_data(rd_data),
    .start_init(start_init), .start_express(start_express), .start_full(start_full)
  );

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // one access (or idle if v==0): drive on falling edge, compare, model update at rising edge
  task automatic step(input int v, input int wr, input int sel);
    int ed, ei, ee, ef;
    string tag;
    @(negedge clk);
    acc_valid = v[0]; acc_write = wr[0]; reg_sel = sel[1:0];
    ed = 0; ei = 0; ee = 0; ef = 0; tag = "R11";
    if (v != 0) begin
      if (sel == 3) tag = "R2";
      else if (sel == 2) begin
        if (m0 && !m1) begin ei = 1; tag = "R5"; end
        else if (m0 && m1) begin ef = 1; tag = "R7"; end
        else tag = "R8";
      end else begin
        if (!m1) begin
          tag = after_clear ? "R2" : "R3";
          ed = (sel == 0) ? card_id[15:8] : card_id[7:0];
        end else if (!m0) begin ei = 1; ed = irq_vec; tag = "R4"; end
        else begin ee = 1; ed = irq_vec; tag = "R6"; end
      end
      if (wr != 0) begin ed = 0; tag = {"R10/", tag}; end
    end
    #2;
    check(tag, "start_init", start_init, ei);
    check(tag, "start_express", start_express, ee);
    check(tag, "start_full", start_full, ef);
    check((v != 0 && sel >= 2 && wr == 0) ? "R9" : tag, "rd_data", rd_data, ed);
    @(posedge clk);
    if (v != 0) begin
      if (sel == 3) begin m0 = 0; m1 = 0; after_clear = 1; end
      else begin
        after_clear = 0;
        if (sel == 2) m1 = 1; else m0 = 1;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; reg_sel = 2'd0;
    card_id = 16'hA53C; irq_vec = 8'h7E;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1: reset state, idle quiet
    step(0, 0, 0); step(0, 0, 2);
    // R3 then R5 then R6/R7 (INT0 first order)
    step(1, 0, 0); step(1, 0, 1); step(1, 0, 2);
    step(1, 0, 0); step(1, 0, 1); step(1, 0, 2); step(1, 0, 3);
    // R2 restart then INT1-first order: R8 then R4
    step(1, 0, 1); step(1, 0, 3);
    step(1, 0, 2); step(1, 0, 2); step(0, 0, 0); step(1, 0, 1);
    step(1, 0, 2); step(1, 0, 0);
    // R9 reads of control/status return zero; R10 writes
    step(1, 1, 3); step(1, 1, 0); step(1, 1, 2); step(1, 1, 1); step(1, 1, 2);
    step(1, 1, 3); step(1, 1, 2); step(1, 0, 0); step(1, 0, 3);
    card_id = 16'h00FF; irq_vec = 8'h01;
    step(1, 0, 0); step(1, 0, 1);
    // pseudo-random stream
    for (int i = 0; i < 600; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
      if (i % 50 == 0) begin card_id = lfsr[31:16]; irq_vec = lfsr[7:0]; end
      step((lfsr[5:3] != 0) ? 1 : 0, lfsr[8], lfsr[1:0]);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule